// File: doc/BRIEF.md
# Prescaled Reload Interval Timer

This block produces a periodic interrupt. A 16-bit count register counts down at a rate set by an 8-bit prescale value. The prescale value is stored as the desired division ratio minus one. When a decrement or a reload leaves the count at zero, the block raises a one-cycle interrupt pulse. On the next count step after that, it refills the count from a 16-bit period register, so the pattern repeats without software intervention.

Software controls the timer through a small word-addressed register port. The port can write and read the control word (which carries the enable bit), the live count, the period and the prescale value. Writing the count replaces it at once. Writing the period changes only what later reloads use, so software can retune the rate while the timer runs without disturbing the interval in progress. Masking and prioritising the interrupt belong to the interrupt controller that receives the pulse.

Top module: `prescaled_interval_timer`

## Requirements
- R1: After a synchronous reset, the count, period, prescale value and enable bit are all zero, and `irq` is low.
- R2: Register selects on `bus_addr`: 0 is control (bit 0 is the enable bit; other bits read as zero), 1 is count, 2 is period, 3 is prescale (low 8 bits; upper bits read as zero). `bus_rdata` shows the selected register in the same cycle, and a write takes effect at the clock edge where `bus_wr` is sampled high.
- R3: While enabled with prescale value S, the count changes once every S+1 clock cycles. With S = 0 it changes every cycle.
- R4: `irq` is high for exactly the one cycle in which a count step has just left the count at zero.
- R5: A count step taken while the count is zero loads the period value instead of decrementing. With a period of 0, every count step raises `irq`.
- R6: With period P and prescale S held constant, successive `irq` pulses are (P+1)*(S+1) cycles apart.
- R7: While the enable bit is clear, the count and the prescaler both hold their values and `irq` stays low.
- R8: A write that sets the enable bit while it was clear restarts the prescaler, so the first count step comes S+1 cycles after that write.
- R9: A count write replaces the count at that edge, overrides any count step due at the same edge, and restarts the prescaler.
- R10: A period write leaves the current count and prescaler phase untouched and is used only by later reloads.
- R11: A prescale write does not shorten or lengthen the prescale phase already under way; the new value applies from the next phase onwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest situations to reach are writes that land exactly on a prescaler tick or in the middle of a prescale phase, because the tick position is invisible at the ports. The bench drives long free-running stretches with a cycle-exact reference model, so the model knows where every tick falls. Count, period and prescale writes are then issued at chosen offsets from an observed interrupt, which places them both on and between ticks. The interrupt spacing is also measured directly from the `irq` output against (P+1)*(S+1), including the period-zero case where every tick raises an interrupt.

// File: rtl/tmr_pkg.sv
// Package: shared register selects for the prescaled interval timer.
// Assumes a two-bit word address on the register port.
package tmr_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_SCALE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tmr_regfile.sv
// Register file of the timer: holds enable, period and prescale value,
// decodes writes into load strobes for the counter and prescaler, and
// returns the selected register (including the live count) combinationally.
// Assumes DATA_W is at least CNT_W and SCL_W.
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int SCL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              enable_o,
    output logic [CNT_W-1:0]  period_o,
    output logic [SCL_W-1:0]  scale_o,
    output logic              count_load_o,
    output logic [CNT_W-1:0]  count_wdata_o,
    output logic              start_o
);
    reg_sel_e sel;
    logic     wr_ctrl, wr_period, wr_scale;

    // Decode the write strobe by register select.
    always_comb begin
        sel           = reg_sel_e'(addr_i);
        wr_ctrl       = wr_i && (sel == SEL_CTRL);
        wr_period     = wr_i && (sel == SEL_PERIOD);
        wr_scale      = wr_i && (sel == SEL_SCALE);
        count_load_o  = wr_i && (sel == SEL_COUNT);
        count_wdata_o = wdata_i[CNT_W-1:0];
        start_o       = wr_ctrl && wdata_i[0] && !enable_o;
    end

    // Hold the software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_o <= 1'b0;
            period_o <= '0;
            scale_o  <= '0;
        end else begin
            if (wr_ctrl)   enable_o <= wdata_i[0];
            if (wr_period) period_o <= wdata_i[CNT_W-1:0];
            if (wr_scale)  scale_o  <= wdata_i[SCL_W-1:0];
        end
    end

    // Return the selected register, zero-extended to the bus width.
    always_comb begin
        unique case (sel)
            SEL_CTRL:   rdata_o = DATA_W'(enable_o);
            SEL_COUNT:  rdata_o = DATA_W'(count_i);
            SEL_PERIOD: rdata_o = DATA_W'(period_o);
            SEL_SCALE:  rdata_o = DATA_W'(scale_o);
            default:    rdata_o = '0;
        endcase
    end

    assert_period_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_period |=> period_o == $past(wdata_i[CNT_W-1:0]));

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> enable_o == $past(wdata_i[0]));
endmodule

// File: rtl/tmr_prescaler.sv
// Prescaler: divides the clock by scale+1 while enabled and emits a
// one-cycle tick at the end of each phase. A restart request reloads the
// phase from the current scale value. Assumes restart and enable come
// from registered logic.
module tmr_prescaler #(
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             restart_i,
    input  logic [SCL_W-1:0] scale_i,
    output logic             tick_o
);
    logic [SCL_W-1:0] phase;

    // A tick falls on the last cycle of an enabled phase.
    always_comb tick_o = enable_i && (phase == '0);

    // Count the phase down, reloading on a tick or a restart.
    always_ff @(posedge clk) begin
        if (!rst_n)            phase <= '0;
        else if (restart_i)    phase <= scale_i;
        else if (tick_o)       phase <= scale_i;
        else if (enable_i)     phase <= phase - 1'b1;
    end

    assert_prescale_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !restart_i) |=> $stable(phase));

    assert_restart_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> phase == $past(scale_i));

    assert_no_tick_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !tick_o);
endmodule

// File: rtl/tmr_downcount.sv
// Down counter with reload: steps once per tick, refilling from the period
// when a step starts at zero, and pulses the interrupt when a step leaves
// the count at zero. A software load overrides the step at the same edge.
module tmr_downcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_value_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] next_count;

    // Choose between a reload and a decrement for the next step.
    always_comb next_count = (count_o == '0) ? period_i : count_o - 1'b1;

    // Apply loads and steps, raising the interrupt on a zero result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            irq_o   <= 1'b0;
        end else begin
            irq_o <= 1'b0;
            if (load_i) begin
                count_o <= load_value_i;
            end else if (tick_i) begin
                count_o <= next_count;
                irq_o   <= (next_count == '0);
            end
        end
    end

    assert_irq_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> count_o == '0);

    assert_count_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !load_i) |=> ($stable(count_o) && !irq_o));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && count_o != '0) |=> count_o == $past(count_o) - 1'b1);

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && count_o == '0) |=> count_o == $past(period_i));

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(load_value_i) && !irq_o));
endmodule

// File: rtl/prescaled_interval_timer.sv
// Top of the prescaled interval timer: joins the register file, the
// prescaler and the reloading down counter. Assumes a single clock domain
// and a synchronous active-low reset.
module prescaled_interval_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int SCL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic             enable, count_load, start, restart, tick;
    logic [CNT_W-1:0] period, count, count_wdata;
    logic [SCL_W-1:0] scale;

    // Restart the prescaler on a count write or on enabling.
    always_comb restart = count_load || start;

    tmr_regfile #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SCL_W(SCL_W)) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_i          (bus_wr),
        .addr_i        (bus_addr),
        .wdata_i       (bus_wdata),
        .count_i       (count),
        .rdata_o       (bus_rdata),
        .enable_o      (enable),
        .period_o      (period),
        .scale_o       (scale),
        .count_load_o  (count_load),
        .count_wdata_o (count_wdata),
        .start_o       (start)
    );

    tmr_prescaler #(.SCL_W(SCL_W)) presc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable),
        .restart_i (restart),
        .scale_i   (scale),
        .tick_o    (tick)
    );

    tmr_downcount #(.CNT_W(CNT_W)) cnt_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable),
        .tick_i       (tick),
        .load_i       (count_load),
        .load_value_i (count_wdata),
        .period_i     (period),
        .count_o      (count),
        .irq_o        (irq)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq && count == '0 && !enable));
endmodule

// File: tb/prescaled_interval_timer_tb.sv
module prescaled_interval_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    always #5 clk = ~clk;

    prescaled_interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string req = "R1";

    // Reference model state
    int m_en = 0, m_cnt = 0, m_per = 0, m_scl = 0, m_wait = 1, m_irq = 0;
    // Interval measurement
    int cyc = 0, last_irq = -1, want_gap = 0;

    task automatic check(string r, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", r, act, exp, cyc);
        end
    endtask

    function automatic int model_read(int a);
        case (a)
            0: return m_en;
            1: return m_cnt;
            2: return m_per;
            default: return m_scl;
        endcase
    endfunction

    task automatic model_update(bit wr, int a, int d);
        bit tk;
        int nxt;
        if (!rst_n) begin
            m_en = 0; m_cnt = 0; m_per = 0; m_scl = 0; m_wait = 1; m_irq = 0;
            return;
        end
        tk = (m_en != 0) && (m_wait == 1);
        m_irq = 0;
        if (wr && a == 1) begin
            m_cnt = d; m_wait = m_scl + 1;
        end else if (tk) begin
            nxt = (m_cnt == 0) ? m_per : m_cnt - 1;
            m_cnt = nxt; m_irq = (nxt == 0); m_wait = m_scl + 1;
        end else if (m_en != 0) begin
            m_wait--;
        end
        if (wr && a == 0) begin
            if ((d & 1) != 0 && m_en == 0) m_wait = m_scl + 1;
            m_en = d & 1;
        end
        if (wr && a == 2) m_per = d;
        if (wr && a == 3) m_scl = d & 255;
    endtask

    // One cycle: compare outputs, drive inputs, advance the model.
    task automatic step(bit wr, int a, int d);
        @(negedge clk);
        check(req, int'(bus_rdata), model_read(int'(bus_addr)));
        check(req, int'(irq), m_irq);
        if (irq) begin
            if (last_irq >= 0 && want_gap > 0) check("R6", cyc - last_irq, want_gap);
            last_irq = cyc;
        end
        bus_wr = wr; bus_addr = 2'(a); bus_wdata = 16'(d);
        @(posedge clk);
        cyc++;
        model_update(wr, a, d);
    endtask

    task automatic idle(int n, int a);
        for (int i = 0; i < n; i++) step(0, a, 0);
    endtask

    task automatic wait_irq();
        int guard = 0;
        do begin step(0, 1, 0); guard++; end while (m_irq == 0 && guard < 70000);
    endtask

    initial begin
        // R1: reset state on every register
        repeat (2) @(posedge clk);
        req = "R1";
        for (int a = 0; a < 4; a++) step(0, a, 0);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) step(0, a, 0);

        // R2: write and read back; reserved bits read zero; enable stays clear
        req = "R2";
        step(1, 2, 16'h1234);
        step(1, 3, 16'hFF05);
        step(1, 0, 16'hFFFE);
        for (int a = 0; a < 4; a++) step(0, a, 0);
        idle(10, 1);

        // R3, R4, R5: scale 0 runs every cycle, reload from period
        req = "R3";
        step(1, 3, 0);
        step(1, 2, 3);
        step(1, 1, 5);
        step(1, 0, 1);
        req = "R4";
        idle(30, 1);

        // R6: interval (P+1)*(S+1) with P=4, S=2
        req = "R6";
        step(1, 3, 2);
        step(1, 2, 4);
        wait_irq(); wait_irq();
        last_irq = -1; want_gap = 15;
        idle(80, 1);
        want_gap = 0;

        // R7: disable mid-phase, everything holds
        req = "R7";
        step(0, 1, 0);
        step(1, 0, 0);
        idle(25, 1);
        // R8: re-enable restarts the prescaler
        req = "R8";
        step(1, 0, 1);
        idle(20, 1);
        // enable rewritten while running: no restart
        step(1, 0, 1);
        idle(10, 1);

        // R9: count write on a tick edge and mid-phase
        req = "R9";
        wait_irq();
        idle(2, 1);
        step(1, 1, 7);
        idle(4, 1);
        step(1, 1, 2);
        idle(20, 1);

        // R10: period write keeps current count
        req = "R10";
        step(1, 2, 9);
        idle(60, 1);

        // R5: period zero gives an irq on every step
        req = "R5";
        step(1, 2, 0);
        step(1, 3, 1);
        wait_irq(); wait_irq();
        last_irq = -1; want_gap = 2;
        idle(20, 1);
        want_gap = 0;

        // R11: scale write mid-phase applies from next phase
        req = "R11";
        step(1, 2, 3);
        step(1, 3, 6);
        step(1, 1, 10);
        idle(3, 1);
        step(1, 3, 1);
        idle(40, 1);

        // R3: large prescale value
        req = "R3";
        step(1, 3, 255);
        step(1, 2, 5);
        step(1, 1, 3);
        wait_irq();
        last_irq = -1; want_gap = 6 * 256;
        idle(3200, 1);
        want_gap = 0;

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule